// File: doc/BRIEF.md
# Flat Operand Address Router

This block gives an execution pipeline one flat address space measured in 32-bit longs. Behind that space sit three memories: a small local register RAM, an auxiliary RAM, and a larger shared main memory. The pipeline presents an operand address, a write strobe, write data and a valid. The router works out which memory the address falls in, performs a single-long access there, and returns the result with a one-cycle done pulse. When the target memory is slower, it holds a stall line high for the extra cycles.

The low part of shared memory is covered by the two local regions. That part stays reachable through an alias window placed just above the top of shared memory. Addresses beyond the alias window map to nothing: they complete at once with zero data and an error flag. Only one access is in flight at a time, and a request presented while the stall line is high is dropped. A build-time option lowers the boundary between the local regions and shared memory from $400 to $300, for configurations where only loads and stores use the flat space.

Top module: `flat_operand_router`

## Requirements
- R1: Addresses $000–$1FF select the local RAM (long index = address bits [8:0]). An accepted local access raises done_o in the next cycle with stall_o low throughout.
- R2: Addresses from $200 up to the local threshold minus one select the auxiliary RAM (index = address bits [8:0]). stall_o is high for AUX_WAIT cycles (default 1), and done_o follows in the cycle after stall_o falls.
- R3: Addresses from the local threshold up to $3FFFF select shared memory at the same address. The model holds 2^SHR_AW longs indexed by the low SHR_AW address bits. stall_o is high for SHR_WAIT cycles (default 3) before done_o.
- R4: Addresses $40000–$403FF reach shared memory longs $000–$3FF, which the local regions otherwise hide.
- R5: stall_o rises in the cycle after an access with wait states is accepted. It stays high until the cycle in which done_o is high, and it is never high together with done_o.
- R6: Addresses $40400 and above return rd_data_o = 0 with err_o high in the done cycle and no stall. A write to them changes no memory.
- R7: A request presented while stall_o is high is ignored and has no effect on any memory.
- R8: With LS_ONLY = 1 the local threshold is $300. The auxiliary region then ends at $2FF, and $300 upward goes to shared memory.
- R9: A read returns the long most recently written at the same memory location. In the done cycle of a write, rd_data_o is 0 and err_o is 0.
- R10: While rst is high and after it is released, stall_o, done_o, err_o and rd_data_o are all 0 until a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request present; taken when stall_o is low |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (19) | Flat long address |
| req_wdata_i | input | 32 | Write data |
| stall_o | output | 1 | Pipeline hold while a slow access is pending |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | 32 | Read data, valid with done_o |
| err_o | output | 1 | Unmapped address, valid with done_o |

## Verification
Errors in the held request or in the wait counter show up at the ports on the very next completion. A countdown that restarts wrongly makes the count of stall cycles before done_o wrong. A held region or index that is wrong shows as data from another bank, or as a missing alias, in the done cycle itself. A request that leaks in while the router is stalled stays hidden until that location is read back. For that reason the bench rereads the location it tried to disturb. Each completion is compared with a scoreboard entry for its data, its error flag and its stall-cycle count.

// File: rtl/oprt_pkg.sv
package oprt_pkg;
  typedef enum logic [1:0] {
    RG_LOCAL  = 2'd0,
    RG_AUX    = 2'd1,
    RG_SHARED = 2'd2,
    RG_NONE   = 2'd3
  } region_e;

  localparam int BANK_AW  = 9;
  localparam int DATA_W   = 32;
  localparam int N_BANKS  = 3;
endpackage

// File: rtl/oprt_decode.sv
module oprt_decode
  import oprt_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int SHR_AW  = 11,
  parameter bit LS_ONLY = 1'b0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [SHR_AW-1:0] idx_o
);
  localparam logic [ADDR_W-1:0] AUX_BASE   = ADDR_W'('h200);
  localparam logic [ADDR_W-1:0] THRESH     = LS_ONLY ? ADDR_W'('h300) : ADDR_W'('h400);
  localparam logic [ADDR_W-1:0] ALIAS_BASE = ADDR_W'('h40000);
  localparam logic [ADDR_W-1:0] ALIAS_END  = ADDR_W'('h40400);

  always_comb begin
    idx_o    = '0;
    region_o = RG_NONE;
    if (addr_i < AUX_BASE) begin
      region_o              = RG_LOCAL;
      idx_o[BANK_AW-1:0]    = addr_i[BANK_AW-1:0];
    end else if (addr_i < THRESH) begin
      region_o              = RG_AUX;
      idx_o[BANK_AW-1:0]    = addr_i[BANK_AW-1:0];
    end else if (addr_i < ALIAS_BASE) begin
      region_o              = RG_SHARED;
      idx_o                 = addr_i[SHR_AW-1:0];
    end else if (addr_i < ALIAS_END) begin
      region_o              = RG_SHARED;
      idx_o[9:0]            = addr_i[9:0];
    end
  end
endmodule

// File: rtl/oprt_sram.sv
module oprt_sram #(
  parameter int DW = 32,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en_i) begin
      if (we_i) mem[addr_i] <= wdata_i;
      rdata_o <= mem[addr_i];
    end
  end
endmodule

// File: rtl/oprt_waitctl.sv
module oprt_waitctl #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [CW-1:0] wait_i,
  output logic          busy_o,
  output logic          fire_o
);
  logic [CW-1:0] cnt_q;

  assign fire_o = busy_o && (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && (wait_i != '0)) begin
      busy_o <= 1'b1;
      cnt_q  <= wait_i;
    end else if (busy_o) begin
      if (cnt_q == CW'(1)) busy_o <= 1'b0;
      cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/flat_operand_router.sv
module flat_operand_router
  import oprt_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int SHR_AW   = 11,
  parameter int AUX_WAIT = 1,
  parameter int SHR_WAIT = 3,
  parameter bit LS_ONLY  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic              stall_o,
  output logic              done_o,
  output logic [31:0]       rd_data_o,
  output logic              err_o
);
  localparam int MAXW = (AUX_WAIT > SHR_WAIT) ? AUX_WAIT : SHR_WAIT;
  localparam int CW   = $clog2(MAXW + 2);

  region_e           in_region, h_region, sel_region, rsp_region;
  logic [SHR_AW-1:0] in_idx, h_idx, sel_idx;
  logic              h_we, sel_we, rsp_rd;
  logic [31:0]       h_wdata, sel_wdata;
  logic [CW-1:0]     n_in;
  logic              busy, fire_held, accept, immediate, fire;
  logic              done_q, err_q;
  logic [31:0]       bank_q [N_BANKS];

  oprt_decode #(.ADDR_W(ADDR_W), .SHR_AW(SHR_AW), .LS_ONLY(LS_ONLY)) u_dec (
    .addr_i   (req_addr_i),
    .region_o (in_region),
    .idx_o    (in_idx)
  );

  always_comb begin
    case (in_region)
      RG_AUX:    n_in = CW'(AUX_WAIT);
      RG_SHARED: n_in = CW'(SHR_WAIT);
      default:   n_in = '0;
    endcase
  end

  assign accept    = req_valid_i && !busy;
  assign immediate = accept && (n_in == '0);

  oprt_waitctl #(.CW(CW)) u_wait (
    .clk     (clk),
    .rst     (rst),
    .start_i (accept),
    .wait_i  (n_in),
    .busy_o  (busy),
    .fire_o  (fire_held)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      h_region <= RG_NONE;
      h_idx    <= '0;
      h_we     <= 1'b0;
      h_wdata  <= '0;
    end else if (accept) begin
      h_region <= in_region;
      h_idx    <= in_idx;
      h_we     <= req_we_i;
      h_wdata  <= req_wdata_i;
    end
  end

  assign sel_region = busy ? h_region : in_region;
  assign sel_idx    = busy ? h_idx    : in_idx;
  assign sel_we     = busy ? h_we     : req_we_i;
  assign sel_wdata  = busy ? h_wdata  : req_wdata_i;
  assign fire       = immediate || fire_held;

  for (genvar k = 0; k < N_BANKS; k++) begin : g_bank
    localparam int AW_K = (k == 2) ? SHR_AW : BANK_AW;
    logic en_k;
    assign en_k = fire && (sel_region == region_e'(2'(k)));
    oprt_sram #(.DW(DATA_W), .AW(AW_K)) u_ram (
      .clk     (clk),
      .en_i    (en_k),
      .we_i    (sel_we),
      .addr_i  (sel_idx[AW_K-1:0]),
      .wdata_i (sel_wdata),
      .rdata_o (bank_q[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      rsp_rd     <= 1'b0;
      rsp_region <= RG_NONE;
    end else begin
      done_q     <= fire;
      err_q      <= fire && (sel_region == RG_NONE);
      rsp_rd     <= !sel_we;
      rsp_region <= sel_region;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (done_q && rsp_rd) begin
      case (rsp_region)
        RG_LOCAL:  rd_data_o = bank_q[0];
        RG_AUX:    rd_data_o = bank_q[1];
        RG_SHARED: rd_data_o = bank_q[2];
        default:   rd_data_o = '0;
      endcase
    end
  end

  assign stall_o = busy;
  assign done_o  = done_q;
  assign err_o   = err_q;
endmodule

// File: rtl/flat_operand_router_chk.sv
module flat_operand_router_chk #(
  parameter int ADDR_W   = 19,
  parameter int SHR_WAIT = 3,
  parameter bit LS_ONLY  = 1'b0
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              stall_o,
  input logic              done_o,
  input logic [31:0]       rd_data_o,
  input logic              err_o
);
  localparam logic [ADDR_W-1:0] THRESH = LS_ONLY ? ADDR_W'('h300) : ADDR_W'('h400);

  logic take;
  assign take = req_valid_i && !stall_o;

  p_stall_done_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(stall_o && done_o));

  p_stall_ends_done_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(stall_o) |-> done_o);

  p_err_zero_r6: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (done_o && rd_data_o == '0));

  p_local_fast_r1: assert property (@(posedge clk) disable iff (rst)
    (take && req_addr_i < ADDR_W'('h200)) |=> (done_o && !stall_o && !err_o));

  p_unmapped_r6: assert property (@(posedge clk) disable iff (rst)
    (take && req_addr_i >= ADDR_W'('h40400)) |=> (done_o && err_o && !stall_o));

  p_shared_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (SHR_WAIT > 0 && take && req_addr_i >= THRESH && req_addr_i < ADDR_W'('h40000))
      |=> (stall_o && !done_o));
endmodule

bind flat_operand_router flat_operand_router_chk #(
  .ADDR_W(ADDR_W), .SHR_WAIT(SHR_WAIT), .LS_ONLY(LS_ONLY)
) u_chk (
  .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
  .stall_o(stall_o), .done_o(done_o), .rd_data_o(rd_data_o), .err_o(err_o)
);

// File: tb/flat_operand_router_test.sv
module flat_operand_router_test;
  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          valid = 1'b0, we = 1'b0, sel_ls = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;

  logic          a_stall, a_done, a_err, l_stall, l_done, l_err;
  logic [31:0]   a_rd, l_rd;
  logic          b_stall, b_done, b_err;
  logic [31:0]   b_rd;

  int checks = 0, fails = 0, stall_cnt = 0;

  logic [31:0] q_rd[$];
  logic        q_err[$];
  int          q_wait[$];
  string       q_tag[$];

  always #2 clk = ~clk;

  flat_operand_router uut (
    .clk(clk), .rst(rst), .req_valid_i(valid && !sel_ls), .req_we_i(we),
    .req_addr_i(addr), .req_wdata_i(wdata), .stall_o(a_stall), .done_o(a_done),
    .rd_data_o(a_rd), .err_o(a_err));

  flat_operand_router #(.LS_ONLY(1'b1)) uut_ls (
    .clk(clk), .rst(rst), .req_valid_i(valid && sel_ls), .req_we_i(we),
    .req_addr_i(addr), .req_wdata_i(wdata), .stall_o(l_stall), .done_o(l_done),
    .rd_data_o(l_rd), .err_o(l_err));

  assign b_stall = sel_ls ? l_stall : a_stall;
  assign b_done  = sel_ls ? l_done  : a_done;
  assign b_err   = sel_ls ? l_err   : a_err;
  assign b_rd    = sel_ls ? l_rd    : a_rd;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (b_stall && b_done) chk(0, "R5", "stall with done", 32'd1, 32'd0);
      if (b_stall) stall_cnt++;
      if (b_done) begin
        if (q_rd.size() == 0) begin
          chk(0, "R5", "unexpected done", 32'd1, 32'd0);
        end else begin
          logic [31:0] e_rd;
          logic        e_err;
          int          e_w;
          string       tg;
          e_rd = q_rd.pop_front(); e_err = q_err.pop_front();
          e_w = q_wait.pop_front(); tg = q_tag.pop_front();
          chk(b_rd == e_rd, tg, "rd_data", b_rd, e_rd);
          chk(b_err == e_err, tg, "err", 32'(b_err), 32'(e_err));
          chk(stall_cnt == e_w, tg, "stall cycles", 32'(stall_cnt), 32'(e_w));
        end
        stall_cnt = 0;
      end
    end
  end

  task automatic issue(input logic w, input logic [AW-1:0] a, input logic [31:0] d,
                       input logic [31:0] exp_rd, input logic exp_err, input int exp_w,
                       input string tag);
    q_rd.push_back(exp_rd); q_err.push_back(exp_err);
    q_wait.push_back(exp_w); q_tag.push_back(tag);
    @(negedge clk);
    valid = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0;
    while (b_stall) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "R5", "watchdog expired", 32'd0, 32'd1);
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R10: outputs quiet in and after reset
    chk(!a_stall && !a_done && !a_err && a_rd == 0, "R10", "in reset", a_rd, 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(!a_stall && !a_done && !a_err && a_rd == 0, "R10", "after reset", a_rd, 32'd0);

    // R1 local, R9 write done gives zero
    issue(1, 19'h005, 32'hA1A1_0005, 32'h0, 0, 0, "R9");
    issue(0, 19'h005, 0, 32'hA1A1_0005, 0, 0, "R1");
    issue(1, 19'h1FF, 32'hA1A1_01FF, 32'h0, 0, 0, "R1");
    issue(0, 19'h1FF, 0, 32'hA1A1_01FF, 0, 0, "R1");
    // R2 auxiliary, boundaries $200 and $3FF
    issue(1, 19'h205, 32'hB2B2_0205, 32'h0, 0, 1, "R2");
    issue(1, 19'h3FF, 32'hB2B2_03FF, 32'h0, 0, 1, "R2");
    issue(0, 19'h205, 0, 32'hB2B2_0205, 0, 1, "R2");
    issue(0, 19'h3FF, 0, 32'hB2B2_03FF, 0, 1, "R2");
    issue(0, 19'h005, 0, 32'hA1A1_0005, 0, 0, "R1");
    // R3 shared at same address
    issue(1, 19'h405, 32'hC3C3_0405, 32'h0, 0, 3, "R3");
    issue(0, 19'h405, 0, 32'hC3C3_0405, 0, 3, "R3");
    // R4 alias window reaches hidden shared longs
    issue(1, 19'h40005, 32'hD4D4_0005, 32'h0, 0, 3, "R4");
    issue(1, 19'h40300, 32'hD4D4_0300, 32'h0, 0, 3, "R4");
    issue(1, 19'h300, 32'hB2B2_0300, 32'h0, 0, 1, "R2");
    issue(0, 19'h40005, 0, 32'hD4D4_0005, 0, 3, "R4");
    issue(0, 19'h40300, 0, 32'hD4D4_0300, 0, 3, "R4");
    issue(0, 19'h005, 0, 32'hA1A1_0005, 0, 0, "R4");
    issue(0, 19'h300, 0, 32'hB2B2_0300, 0, 1, "R4");
    // R6 unmapped
    issue(0, 19'h40400, 0, 32'h0, 1, 0, "R6");
    issue(1, 19'h7FFFF, 32'hEEEE_EEEE, 32'h0, 1, 0, "R6");
    issue(0, 19'h7FFFF, 0, 32'h0, 1, 0, "R6");

    // R7: intruding write to local $005 while a shared read stalls
    q_rd.push_back(32'hC3C3_0405); q_err.push_back(0);
    q_wait.push_back(3); q_tag.push_back("R7");
    @(negedge clk);
    valid = 1'b1; we = 1'b0; addr = 19'h405;
    @(negedge clk);
    we = 1'b1; addr = 19'h005; wdata = 32'hBAD0_BAD0;
    @(negedge clk);
    valid = 1'b0;
    while (b_stall) @(negedge clk);
    issue(0, 19'h005, 0, 32'hA1A1_0005, 0, 0, "R7");

    // R8: load/store-only threshold on second instance
    @(negedge clk);
    sel_ls = 1'b1;
    issue(1, 19'h300, 32'hF8F8_0300, 32'h0, 0, 3, "R8");
    issue(0, 19'h40300, 0, 32'hF8F8_0300, 0, 3, "R8");
    issue(1, 19'h2FF, 32'hF8F8_02FF, 32'h0, 0, 1, "R8");
    issue(0, 19'h2FF, 0, 32'hF8F8_02FF, 0, 1, "R8");

    repeat (4) @(negedge clk);
    chk(q_rd.size() == 0, "R5", "pending items", 32'(q_rd.size()), 32'd0);
    summary();
    $finish;
  end
endmodule